// File: doc/BRIEF.md
# Fast Ethernet PCS Transmit Framer

This block sits between a 4-bit media-independent transmit interface and the line-coding stage of a 100 Mb/s port. On every 25 MHz nibble clock it turns the incoming nibble into one 5-bit code-group. While no frame is in progress it fills the line with idle code-groups.

When a frame starts, the block drops the first preamble octet and sends the start-of-stream delimiter in its place. It then translates every later nibble through the 4B/5B table. When transmit enable falls, it closes the stream with the end-of-stream delimiter.

A symbol-mode input bypasses the table. In that mode the caller supplies raw 5-bit code-groups, with the error input acting as the fifth bit. The output is registered, so each symbol appears exactly one clock after the nibble it belongs to.

Top module: `fe_tx_framer`

## Requirements
- R1: After reset the output `sym_out` is the idle code-group 11111, and it stays 11111 on every clock while `tx_en` is low and no frame is closing.
- R2: On the first clock with `tx_en` high after idle, the output of the next cycle is /J/ (11000). The cycle after that is always /K/ (10001). The two nibbles presented in those cycles are not sent.
- R3: After /K/, each nibble presented with `tx_en` high, `tx_er` low and `sym_mode` low appears one clock later as its 4B/5B code-group. The codes for nibbles 0 through 15 are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: In the first data-phase clock with `tx_en` low, the next output is /T/ (01101) with no gap, and the output after that is /R/ (00111).
- R5: After /R/ the block returns to idle. A `tx_en` that is high in the clock that produces /R/ does not start a frame; a frame starts on the first clock after that with `tx_en` high.
- R6: With `sym_mode` high in the data phase, the output is `{tx_er, txd[3:0]}`, with `tx_er` as bit 4. /J/, /K/, /T/ and /R/ are still inserted.
- R7: With `sym_mode` low, a data-phase nibble presented with `tx_en` and `tx_er` both high is sent as the error code-group 00100.
- R8: `tx_er`, `txd` and `sym_mode` have no effect on the idle, /J/, /K/, /T/ or /R/ code-groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Frame valid from the MAC |
| tx_er | input | 1 | Error flag; fifth symbol bit in symbol mode |
| txd | input | 4 | Transmit nibble |
| sym_mode | input | 1 | 1 = bypass the 4B/5B table |
| sym_out | output | 5 | Registered code-group, one per clock |

## Verification
The bench builds the block with its default widths: 4-bit nibbles, 5-bit symbols and a two-stage reset synchronizer. These widths are small enough to sweep in full. One frame walks all 16 nibble values through the table. A symbol-mode frame walks all 32 combinations of error bit and nibble.

Further frames cover the following cases:
- the error code-group on alternate nibbles;
- a frame that ends during the start delimiter;
- an enable re-raised in the /R/ cycle;
- noise on the error and mode inputs while idle and during the delimiters.

// File: rtl/fe_pcs_pkg.sv
package fe_pcs_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t CG_IDLE = 5'b11111;
  localparam sym_t CG_J    = 5'b11000;
  localparam sym_t CG_K    = 5'b10001;
  localparam sym_t CG_T    = 5'b01101;
  localparam sym_t CG_R    = 5'b00111;
  localparam sym_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SSD2 = 2'd1,
    ST_DATA = 2'd2,
    ST_ESD2 = 2'd3
  } fr_state_e;
endpackage

// File: rtl/fe_rst_sync.sv
module fe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fe_4b5b_enc.sv
module fe_4b5b_enc
  import fe_pcs_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output sym_t             code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/fe_data_sel.sv
module fe_data_sel
  import fe_pcs_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             err,
  input  logic             bypass,
  input  sym_t             table_code,
  output sym_t             data_sym
);
  always_comb begin
    if (bypass)   data_sym = {err, nib};
    else if (err) data_sym = CG_H;
    else          data_sym = table_code;
  end
endmodule

// File: rtl/fe_tx_seq.sv
module fe_tx_seq
  import fe_pcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  sym_t      data_sym,
  output sym_t      sym_next,
  output fr_state_e st_q
);
  fr_state_e st_d;

  always_comb begin
    st_d     = st_q;
    sym_next = CG_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_en) begin
          sym_next = CG_J;
          st_d     = ST_SSD2;
        end
      end
      ST_SSD2: begin
        sym_next = CG_K;
        st_d     = ST_DATA;
      end
      ST_DATA: begin
        if (tx_en) begin
          sym_next = data_sym;
        end else begin
          sym_next = CG_T;
          st_d     = ST_ESD2;
        end
      end
      default: begin
        sym_next = CG_R;
        st_d     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
  import fe_pcs_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  input  logic             sym_mode,
  output logic [SYM_W-1:0] sym_out
);
  logic      rst_sync_n;
  sym_t      table_code;
  sym_t      data_sym;
  sym_t      sym_next;
  sym_t      sym_q;
  fr_state_e st_q;

  fe_rst_sync #(.STAGES(RST_STAGES)) rsync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fe_4b5b_enc enc_i (.nib(txd), .code(table_code));

  fe_data_sel sel_i (
    .nib(txd), .err(tx_er), .bypass(sym_mode),
    .table_code(table_code), .data_sym(data_sym)
  );

  fe_tx_seq seq_i (
    .clk(clk), .rst_n(rst_sync_n), .tx_en(tx_en),
    .data_sym(data_sym), .sym_next(sym_next), .st_q(st_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sym_q <= CG_IDLE;
    else             sym_q <= sym_next;
  end

  assign sym_out = sym_q;
endmodule

// File: rtl/fe_tx_framer_chk.sv
module fe_tx_framer_chk
  import fe_pcs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_er,
  input logic [NIB_W-1:0] txd,
  input logic             sym_mode,
  input fr_state_e        st,
  input logic [SYM_W-1:0] sym_out
);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !tx_en) |=> (sym_out == CG_IDLE));

  p_j_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && tx_en) |=> (sym_out == CG_J && st == ST_SSD2));

  p_k_after_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SSD2) |=> (sym_out == CG_K));

  p_t_on_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !tx_en) |=> (sym_out == CG_T && st == ST_ESD2));

  p_r_after_t_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ESD2) |=> (sym_out == CG_R));

  p_back_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ESD2) |=> (st == ST_IDLE));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && tx_en && sym_mode) |=> (sym_out == {$past(tx_er), $past(txd)}));

  p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && tx_en && tx_er && !sym_mode) |=> (sym_out == CG_H));

  p_er_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SSD2 && tx_er && sym_mode) |=> (sym_out == CG_K));
endmodule

bind fe_tx_framer fe_tx_framer_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n), .tx_en(tx_en), .tx_er(tx_er),
  .txd(txd), .sym_mode(sym_mode), .st(st_q), .sym_out(sym_out)
);

// File: tb/fe_tx_framer_tb_top.sv
module fe_tx_framer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tx_en;
  logic       tx_er;
  logic [3:0] txd;
  logic       sym_mode;
  logic [4:0] sym_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [4:0] IDL = 5'b11111, SJ = 5'b11000, SK = 5'b10001;
  localparam logic [4:0] ST = 5'b01101, SR = 5'b00111, SH = 5'b00100;

  fe_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .sym_mode(sym_mode), .sym_out(sym_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input logic [4:0] exp, input string tag);
    n_tests++;
    if (sym_out !== exp) begin
      n_fail++;
      $display("FAIL %s: sym_out=%b expected=%b", tag, sym_out, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic sm,
                      input logic [3:0] d, input logic [4:0] exp, input string tag);
    @(negedge clk);
    tx_en = en; tx_er = er; sym_mode = sm; txd = d;
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0; sym_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(IDL, "R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(IDL, "R1");

    // idle with noise on other inputs
    for (int i = 0; i < 8; i++) step(0, i[0], i[1], 4'(i * 3), IDL, "R8");

    // full table frame
    step(1, 0, 0, 4'h5, SJ, "R2");
    step(1, 1, 1, 4'h5, SK, "R8");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 4'(i), enc(4'(i)), "R3");
    step(0, 1, 1, 4'h0, ST, "R4");
    step(0, 1, 0, 4'h9, SR, "R4");
    step(0, 0, 0, 4'h0, IDL, "R5");

    // error code-group on alternate nibbles
    step(1, 0, 0, 4'h5, SJ, "R2");
    step(1, 0, 0, 4'hD, SK, "R2");
    for (int i = 0; i < 16; i++)
      step(1, i[0], 0, 4'(i), i[0] ? SH : enc(4'(i)), "R7");
    step(0, 0, 0, 4'h0, ST, "R4");
    // enable re-raised in the /R/ cycle is ignored
    step(1, 0, 0, 4'h3, SR, "R5");
    step(1, 0, 0, 4'h5, SJ, "R5");
    step(1, 0, 0, 4'h5, SK, "R5");
    step(1, 0, 0, 4'hA, enc(4'hA), "R3");
    step(0, 0, 0, 4'h0, ST, "R4");
    step(0, 0, 0, 4'h0, SR, "R4");
    step(0, 0, 0, 4'h0, IDL, "R1");

    // symbol mode sweep
    step(1, 1, 1, 4'h5, SJ, "R6");
    step(1, 0, 1, 4'h5, SK, "R6");
    for (int v = 0; v < 32; v++) step(1, v[4], 1, 4'(v), 5'(v), "R6");
    step(0, 1, 1, 4'h7, ST, "R6");
    step(0, 0, 1, 4'h7, SR, "R6");
    step(0, 0, 1, 4'h0, IDL, "R6");

    // frame dropped during the start delimiter
    step(1, 0, 0, 4'h5, SJ, "R2");
    step(0, 0, 0, 4'h5, SK, "R2");
    step(0, 0, 0, 4'h0, ST, "R4");
    step(0, 0, 0, 4'h0, SR, "R4");
    step(0, 0, 0, 4'h0, IDL, "R5");
    step(0, 1, 0, 4'hF, IDL, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule